// File: doc/BRIEF.md
# Three-Wire Memory Card Bus Monitor

This block passively watches a synchronous three-wire memory card link, which has a card reset line, a card clock line and a bidirectional data line. It never drives the link. All three lines are sampled on a much faster system clock. The block finds the bus conditions on those samples, shifts sampled data bits into bytes, and gives out each completed byte together with a tag. The tag says which phase of the exchange the byte belongs to.

A rising card reset starts the answer-to-reset phase. The data line falling while the card clock is high opens a command. The data line rising while the card clock is high closes the command, and the card's response data follows. Each of these three conditions empties the byte collector and gives a one-cycle event pulse. Bits are taken on rising card clock edges while card reset is low, least significant bit first. Downstream logic consumes the tagged byte stream and the event pulses.

Top module: `cardbus_sniffer`

## Requirements
- R1: A synchronous active-high system reset leaves byte_valid_o low, all event pulses low and tag_o at 0. The phase tag is none (0) until the first card reset edge.
- R2: While the synchronized card reset is low, each rising card clock edge samples the data line as one bit, least significant first. After 8 bits, byte_valid_o pulses for exactly one system cycle with the byte on byte_o.
- R3: Rising card clock edges while card reset is high sample no bit, and no byte results from them.
- R4: A rising card reset edge pulses reset_evt_o for one cycle and discards any partial byte. Every following byte carries tag 1 (answer-to-reset).
- R5: A falling data-line edge while the card clock is high pulses cmd_start_evt_o and discards any partial byte. Following bytes carry tag 2 (command).
- R6: A rising data-line edge while the card clock is high pulses cmd_stop_evt_o and discards any partial byte. Following bytes carry tag 3 (card data).
- R7: A byte completed before any card reset edge carries tag 0 (none).
- R8: When a card reset edge and a data-line edge under a high clock fall in the same system cycle, only the reset event is produced. The phase becomes answer-to-reset.
- R9: After each completed byte the collector restarts, so back-to-back bytes are each assembled from their own 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the card clock |
| rst | input | 1 | Synchronous active-high system reset |
| card_rst_i | input | 1 | Card reset line (asynchronous) |
| card_clk_i | input | 1 | Card clock line (asynchronous) |
| card_io_i | input | 1 | Card data line (asynchronous) |
| byte_valid_o | output | 1 | One-cycle strobe for a completed byte |
| byte_o | output | DATA_W | Completed byte, first received bit in bit 0 |
| tag_o | output | 2 | Phase of the byte: 0 none, 1 answer-to-reset, 2 command, 3 data |
| reset_evt_o | output | 1 | One-cycle pulse on a card reset edge |
| cmd_start_evt_o | output | 1 | One-cycle pulse on command start |
| cmd_stop_evt_o | output | 1 | One-cycle pulse on command stop |

## Verification
The assertions check on every cycle that at most one condition fires per cycle. They also check that each condition sets the phase tag it implies and empties the bit counter, that the phase tag changes only on a condition, that no byte completes while card reset is high, and that the byte strobe never lasts two cycles. The bench scenarios are the only place to show that the byte values really come out least significant bit first. They also show that partial bytes are thrown away rather than merged, that the tag stays none before the first card reset, and that the reset-over-command priority holds when both edges line up.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [1:0] {
    TAG_NONE = 2'd0,
    TAG_ATR  = 2'd1,
    TAG_CMD  = 2'd2,
    TAG_DATA = 2'd3
  } cbs_tag_e;

  // line indices inside the synchronized bundle
  localparam int LN_RST = 0;
  localparam int LN_CLK = 1;
  localparam int LN_IO  = 2;
  localparam int LN_CNT = 3;

  typedef struct packed {
    logic reset;
    logic cmd_start;
    logic cmd_stop;
    logic bit_take;
  } cbs_evt_t;

  // phase tag after the events of one cycle (reset has priority)
  function automatic cbs_tag_e tag_after(cbs_tag_e cur, cbs_evt_t e);
    if (e.reset)          return TAG_ATR;
    else if (e.cmd_start) return TAG_CMD;
    else if (e.cmd_stop)  return TAG_DATA;
    else                  return cur;
  endfunction

  // any condition that empties the collector
  function automatic logic clears_collector(cbs_evt_t e);
    return e.reset | e.cmd_start | e.cmd_stop;
  endfunction

endpackage

// File: rtl/cbs_sync.sv
module cbs_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] lvl_prev
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-1:0], d[i]};
    end
    assign lvl[i]      = chain[STAGES-1];
    assign lvl_prev[i] = chain[STAGES];
  end
endmodule

// File: rtl/cbs_event.sv
module cbs_event
  import cbs_pkg::*;
(
  input  logic [LN_CNT-1:0] lvl,
  input  logic [LN_CNT-1:0] lvl_prev,
  output cbs_evt_t          ev
);
  logic rst_rise, clk_rise, clk_steady_high, io_fall, io_rise;

  always_comb begin
    rst_rise        = lvl[LN_RST] & ~lvl_prev[LN_RST];
    clk_rise        = lvl[LN_CLK] & ~lvl_prev[LN_CLK];
    clk_steady_high = lvl[LN_CLK] &  lvl_prev[LN_CLK];
    io_fall         = ~lvl[LN_IO] &  lvl_prev[LN_IO];
    io_rise         =  lvl[LN_IO] & ~lvl_prev[LN_IO];

    ev.reset     = rst_rise;
    ev.cmd_start = ~rst_rise & clk_steady_high & io_fall;
    ev.cmd_stop  = ~rst_rise & clk_steady_high & io_rise;
    ev.bit_take  = ~rst_rise & ~ev.cmd_start & ~ev.cmd_stop &
                   ~lvl[LN_RST] & clk_rise;
  end
endmodule

// File: rtl/cbs_collect.sv
module cbs_collect
  import cbs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  cbs_evt_t          ev,
  input  logic              io_lvl,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_q,
  output logic [1:0]        byte_tag,
  output logic [1:0]        cur_tag,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  cbs_tag_e          phase;
  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] sr_next;

  assign sr_next = {io_lvl, sr[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= TAG_NONE;
      sr         <= '0;
      bit_cnt    <= '0;
      byte_valid <= 1'b0;
      byte_q     <= '0;
      byte_tag   <= TAG_NONE;
    end else begin
      phase      <= tag_after(phase, ev);
      byte_valid <= 1'b0;
      if (clears_collector(ev)) begin
        sr      <= '0;
        bit_cnt <= '0;
      end else if (ev.bit_take) begin
        if (bit_cnt == LAST) begin
          sr         <= '0;
          bit_cnt    <= '0;
          byte_valid <= 1'b1;
          byte_q     <= sr_next;
          byte_tag   <= phase;
        end else begin
          sr      <= sr_next;
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign cur_tag = phase;
endmodule

// File: rtl/cardbus_sniffer.sv
module cardbus_sniffer
  import cbs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              card_rst_i,
  input  logic              card_clk_i,
  input  logic              card_io_i,
  output logic              byte_valid_o,
  output logic [DATA_W-1:0] byte_o,
  output logic [1:0]        tag_o,
  output logic              reset_evt_o,
  output logic              cmd_start_evt_o,
  output logic              cmd_stop_evt_o
);
  logic [LN_CNT-1:0] raw, lvl, lvl_prev;
  cbs_evt_t          ev;
  logic [1:0]        cur_tag;
  logic [CNT_W-1:0]  bit_cnt;
  logic              rst_lvl, bit_take;

  always_comb begin
    raw         = '0;
    raw[LN_RST] = card_rst_i;
    raw[LN_CLK] = card_clk_i;
    raw[LN_IO]  = card_io_i;
  end

  cbs_sync #(.STAGES(SYNC_STAGES), .LINES(LN_CNT)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .lvl(lvl), .lvl_prev(lvl_prev)
  );

  cbs_event u_event (.lvl(lvl), .lvl_prev(lvl_prev), .ev(ev));

  cbs_collect #(.DATA_W(DATA_W)) u_collect (
    .clk(clk), .rst(rst), .ev(ev), .io_lvl(lvl[LN_IO]),
    .byte_valid(byte_valid_o), .byte_q(byte_o), .byte_tag(tag_o),
    .cur_tag(cur_tag), .bit_cnt(bit_cnt)
  );

  assign reset_evt_o     = ev.reset;
  assign cmd_start_evt_o = ev.cmd_start;
  assign cmd_stop_evt_o  = ev.cmd_stop;
  assign rst_lvl         = lvl[LN_RST];
  assign bit_take        = ev.bit_take;
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             reset_evt,
  input logic             cmd_start,
  input logic             cmd_stop,
  input logic             bit_take,
  input logic             byte_valid,
  input logic             rst_lvl,
  input logic [1:0]       cur_tag,
  input logic [CNT_W-1:0] bit_cnt
);
  // R8
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reset_evt, cmd_start, cmd_stop, bit_take}));
  // R4
  atr_tag_chk: assert property (@(posedge clk) disable iff (rst)
    reset_evt |=> cur_tag == 2'd1);
  // R5
  cmd_tag_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> cur_tag == 2'd2);
  // R6
  data_tag_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stop |=> cur_tag == 2'd3);
  // R4
  clear_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (reset_evt || cmd_start || cmd_stop) |=> bit_cnt == '0);
  // R1
  tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(reset_evt || cmd_start || cmd_stop) |=> $stable(cur_tag));
  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);
  // R3
  no_byte_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    rst_lvl |=> !byte_valid);
endmodule

bind cardbus_sniffer cbs_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reset_evt(reset_evt_o), .cmd_start(cmd_start_evt_o),
  .cmd_stop(cmd_stop_evt_o), .bit_take(bit_take), .byte_valid(byte_valid_o),
  .rst_lvl(rst_lvl), .cur_tag(cur_tag), .bit_cnt(bit_cnt)
);

// File: tb/tb_cardbus_sniffer.sv
module tb_cardbus_sniffer;
  localparam int HP = 4;  // system cycles per card clock half period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic card_rst = 1'b0, card_clk = 1'b0, card_io = 1'b0;
  logic       byte_valid;
  logic [7:0] byte_v;
  logic [1:0] tag;
  logic       r_evt, s_evt, p_evt;

  always #2 clk = ~clk;  // 250 MHz

  cardbus_sniffer dut (
    .clk(clk), .rst(rst), .card_rst_i(card_rst), .card_clk_i(card_clk),
    .card_io_i(card_io), .byte_valid_o(byte_valid), .byte_o(byte_v),
    .tag_o(tag), .reset_evt_o(r_evt), .cmd_start_evt_o(s_evt),
    .cmd_stop_evt_o(p_evt)
  );

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  logic [9:0] got_q[$];
  logic [9:0] exp_q[$];
  int n_r = 0, n_s = 0, n_p = 0, wide = 0;
  logic prev_valid = 1'b0, prev_r = 1'b0, prev_s = 1'b0, prev_p = 1'b0;
  logic [1:0] phase = 2'd0;  // bench view of the tag

  // monitor away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (byte_valid) got_q.push_back({tag, byte_v});
      if (r_evt) n_r++;
      if (s_evt) n_s++;
      if (p_evt) n_p++;
      if ((byte_valid && prev_valid) || (r_evt && prev_r) ||
          (s_evt && prev_s) || (p_evt && prev_p)) wide++;
    end
    prev_valid = byte_valid; prev_r = r_evt; prev_s = s_evt; prev_p = p_evt;
  end

  function automatic logic [9:0] pack_exp(logic [1:0] t, logic [7:0] b);
    return {t, b};
  endfunction

  task automatic chk(string req, int got, int exp, string what);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    card_io = b; tick(HP);
    card_clk = 1'b1; tick(HP);
    card_clk = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b, bit expect_it);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    if (expect_it) exp_q.push_back(pack_exp(phase, b));
  endtask

  task automatic card_reset();
    tick(HP); card_rst = 1'b1; tick(HP); card_rst = 1'b0; tick(HP);
    phase = 2'd1;
  endtask

  task automatic cmd_start();
    card_io = 1'b1; tick(HP); card_clk = 1'b1; tick(HP);
    card_io = 1'b0; tick(HP); card_clk = 1'b0; tick(HP);
    phase = 2'd2;
  endtask

  task automatic cmd_stop();
    card_io = 1'b0; tick(HP); card_clk = 1'b1; tick(HP);
    card_io = 1'b1; tick(HP); card_clk = 1'b0; tick(HP);
    phase = 2'd3;
  endtask

  task automatic drain_and_compare(string req);
    tick(4 * HP);
    chk(req, got_q.size(), exp_q.size(), "byte count");
    for (int i = 0; i < exp_q.size(); i++) begin
      if (i < got_q.size()) chk(req, int'(got_q[i]), int'(exp_q[i]), "tag/byte");
    end
    got_q.delete(); exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int er = 0, es = 0, ep = 0;
    void'($urandom(32'h1357_2468));
    tick(5);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1", byte_valid, 0, "byte_valid after reset");
    chk("R1", tag, 0, "tag after reset");
    chk("R1", {r_evt, s_evt, p_evt}, 0, "event pulses after reset");

    // R7 byte before any card reset carries tag none
    send_byte(8'hA5, 1'b1);
    drain_and_compare("R7");

    // R4 + R2 answer-to-reset bytes, LSB first
    card_reset(); er++;
    send_byte(8'h01, 1'b1);
    send_byte(8'h80, 1'b1);
    drain_and_compare("R2");

    // R4 partial byte discarded by card reset
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    card_reset(); er++;
    send_byte(8'h3C, 1'b1);
    drain_and_compare("R4");

    // R5 partial byte discarded by command start
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    cmd_start(); es++;
    send_byte(8'hC3, 1'b1);
    drain_and_compare("R5");

    // R6 partial byte discarded by command stop, data tag
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    cmd_stop(); ep++;
    send_byte(8'h5A, 1'b1);
    drain_and_compare("R6");

    // R3 clock edges while card reset is high sample nothing
    card_rst = 1'b1; tick(2 * HP); er++;
    for (int i = 0; i < 8; i++) send_bit(i[0]);
    card_rst = 1'b0; tick(HP); phase = 2'd1;
    drain_and_compare("R3");
    send_byte(8'h96, 1'b1);
    drain_and_compare("R3");

    // R8 reset edge and command-start edge in the same cycle
    cmd_stop(); ep++;
    card_io = 1'b1; tick(HP); card_clk = 1'b1; tick(HP);
    card_rst = 1'b1; card_io = 1'b0; tick(HP); er++; phase = 2'd1;
    card_clk = 1'b0; tick(HP); card_rst = 1'b0; tick(HP);
    send_byte(8'h7E, 1'b1);
    drain_and_compare("R8");
    chk("R8", n_s, es, "cmd_start pulses");

    // R9 random sessions with back-to-back bytes
    for (int round = 0; round < 6; round++) begin
      card_reset(); er++;
      for (int k = 0; k < 1 + int'($urandom_range(2)); k++)
        send_byte(8'($urandom), 1'b1);
      cmd_start(); es++;
      for (int k = 0; k < 3; k++) send_byte(8'($urandom), 1'b1);
      cmd_stop(); ep++;
      for (int k = 0; k < 1 + int'($urandom_range(4)); k++)
        send_byte(8'($urandom), 1'b1);
      drain_and_compare("R9");
    end

    chk("R4", n_r, er, "reset pulses");
    chk("R5", n_s, es, "cmd_start pulses");
    chk("R6", n_p, ep, "cmd_stop pulses");
    chk("R2", wide, 0, "strobes wider than one cycle");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule